// File: doc/BRIEF.md
# Decode-Stage Hazard Stall and Flush Controller

This block is the hazard controller that sits beside the decode stage of a five-stage in-order pipeline in which branch comparison and target selection happen in decode. Each cycle it looks at the instruction waiting in decode and at the instructions in execute and memory. From these it decides whether the front of the pipeline must freeze, whether a bubble must go into execute, and whether the instruction just fetched must be squashed.

Two situations freeze the front end. The first is a load in execute whose destination is read by the decode instruction. The second is a branch in decode whose compare operand is still being produced by the ALU instruction in execute. While frozen, the program counter and fetch/decode register keep their values and the control bits entering execute are forced to zero. A jump, or a branch whose compare came out taken, squashes the fetched instruction, but only in a cycle with no freeze. The block also drives two single-bit selects that steer the memory-stage result into the decode comparator.

The block is purely combinational. The clock and reset serve only the embedded checks.

Top module: `hazard_ctl`

## Requirements
- R1: A load-use hazard is detected when `ex_is_load` is 1 and `ex_rt` equals `id_rs` or `id_rt`. Register 0 is not excluded from this comparison.
- R2: While any hazard is detected, `pc_we` and `ifid_we` are 0. Otherwise both are 1.
- R3: While any hazard is detected, `ctl_zero` is 1, which selects zeros for the control fields entering execute. Otherwise it is 0.
- R4: With no load in execute and no branch dependence, no stall occurs. Because the inserted bubble carries `ex_is_load`=0, a load-use hazard therefore costs exactly one bubble cycle.
- R5: A branch-operand hazard is detected when `id_branch` is 1, `ex_wr` is 1, `ex_dst` is nonzero, and `ex_dst` equals `id_rs` or `id_rt`.
- R6: `fwd_cmp_a` is 1 exactly when `id_branch`, `mem_wr` are 1, `mem_dst` is nonzero and equals `id_rs`. `fwd_cmp_b` follows the same rule with `id_rt`.
- R7: Register 0 as a destination never causes a branch-operand stall or a compare forward.
- R8: `if_flush` is 1 when `id_jump` is 1, or when `id_branch` and `cmp_eq` are both 1. A branch with `cmp_eq`=0 does not flush.
- R9: Stall has priority over redirect: `if_flush` is 0 in any cycle where a hazard is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Asynchronous active-low reset for the checks |
| ex_is_load | input | 1 | Instruction in execute reads memory |
| ex_rt | input | AW | Rt field of the instruction in execute |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_dst | input | AW | Write destination of the instruction in execute |
| mem_wr | input | 1 | Instruction in memory stage writes a register |
| mem_dst | input | AW | Write destination of the instruction in memory stage |
| id_rs | input | AW | First source register of the decode instruction |
| id_rt | input | AW | Second source register of the decode instruction |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| id_jump | input | 1 | Decode instruction is an unconditional jump |
| cmp_eq | input | 1 | Decode compare outcome, 1 means branch taken |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctl_zero | output | 1 | Select zeros for control fields entering execute |
| if_flush | output | 1 | Zero the instruction field of the fetch/decode register |
| fwd_cmp_a | output | 1 | Take the memory-stage result for compare operand A |
| fwd_cmp_b | output | 1 | Take the memory-stage result for compare operand B |

## Verification
The hardest case to reach is the overlap of a taken branch with an operand that is still in flight. The branch must hold, and the flush must not fire, while `cmp_eq` already reads taken. Related overlaps are a load and an ALU producer that both match, and register 0 appearing in several fields at once. With a 2-bit register index, every combination of all sixteen input bits is swept, so all of these coincidences are covered. Expected outputs are derived from the requirement formulas. A directed sequence then shows the single bubble that follows a load.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef struct packed {
    logic load_use;
    logic br_dep;
  } hz_cause_t;

  function automatic logic any_hazard(input hz_cause_t c);
    return c.load_use | c.br_dep;
  endfunction
endpackage

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int AW = 5
) (
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          hit
);
  logic [1:0] src_match;

  always_comb begin
    src_match[0] = (ex_rt == id_rs);
    src_match[1] = (ex_rt == id_rt);
    hit          = ex_is_load & (|src_match);
  end
endmodule

// File: rtl/hz_brdep.sv
module hz_brdep #(
  parameter int AW = 5
) (
  input  logic          id_branch,
  input  logic          ex_wr,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_dst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  output logic          stall,
  output logic [1:0]    fwd
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] src;
  logic [NSRC-1:0]         ex_hit;
  logic                    ex_live;
  logic                    mem_live;

  assign src[0]   = id_rs;
  assign src[1]   = id_rt;
  assign ex_live  = ex_wr  & (ex_dst  != '0);
  assign mem_live = mem_wr & (mem_dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign ex_hit[g] = ex_live & (ex_dst == src[g]);
    assign fwd[g]    = id_branch & mem_live & (mem_dst == src[g]);
  end

  assign stall = id_branch & (|ex_hit);
endmodule

// File: rtl/hz_redirect.sv
module hz_redirect (
  input  logic hold,
  input  logic id_branch,
  input  logic id_jump,
  input  logic cmp_eq,
  output logic flush
);
  logic redirect;

  always_comb begin
    redirect = id_jump | (id_branch & cmp_eq);
    flush    = redirect & ~hold;
  end
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex_is_load,
  input  logic [AW-1:0] ex_rt,
  input  logic          ex_wr,
  input  logic [AW-1:0] ex_dst,
  input  logic          mem_wr,
  input  logic [AW-1:0] mem_dst,
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_branch,
  input  logic          id_jump,
  input  logic          cmp_eq,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ctl_zero,
  output logic          if_flush,
  output logic          fwd_cmp_a,
  output logic          fwd_cmp_b
);
  hz_cause_t  cause;
  logic       hold;
  logic [1:0] fwd;

  hz_loaduse #(.AW(AW)) u_lu (
    .ex_is_load (ex_is_load),
    .ex_rt      (ex_rt),
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .hit        (cause.load_use)
  );

  hz_brdep #(.AW(AW)) u_bd (
    .id_branch (id_branch),
    .ex_wr     (ex_wr),
    .ex_dst    (ex_dst),
    .mem_wr    (mem_wr),
    .mem_dst   (mem_dst),
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .stall     (cause.br_dep),
    .fwd       (fwd)
  );

  assign hold = any_hazard(cause);

  hz_redirect u_rd (
    .hold      (hold),
    .id_branch (id_branch),
    .id_jump   (id_jump),
    .cmp_eq    (cmp_eq),
    .flush     (if_flush)
  );

  assign pc_we     = ~hold;
  assign ifid_we   = ~hold;
  assign ctl_zero  = hold;
  assign fwd_cmp_a = fwd[0];
  assign fwd_cmp_b = fwd[1];

  // R1 / R2: a matching load in execute freezes the front end
  p_load_freeze_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_is_load && (ex_rt == id_rs)) |-> (!pc_we && !ifid_we && ctl_zero));

  // R5: a dependent branch inserts a bubble
  p_branch_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_branch && ex_wr && ex_dst != '0 && ex_dst == id_rt) |-> ctl_zero);

  // R9: no squash while frozen
  p_no_flush_in_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |-> !if_flush);

  // R6 / R7: compare forward only for a branch with a nonzero producer
  p_fwd_branch_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_cmp_a || fwd_cmp_b) |-> (id_branch && mem_wr && mem_dst != '0));

  // R8: a squash always has a redirect behind it
  p_flush_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    if_flush |-> (id_jump || (id_branch && cmp_eq)));

  // R4: without any producer match, the front end advances
  p_free_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_is_load && !id_branch) |-> (pc_we && ifid_we && !ctl_zero));
endmodule

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int AW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ex_is_load, ex_wr, mem_wr, id_branch, id_jump, cmp_eq;
  logic [AW-1:0] ex_rt, ex_dst, mem_dst, id_rs, id_rt;
  logic pc_we, ifid_we, ctl_zero, if_flush, fwd_cmp_a, fwd_cmp_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_ctl #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ex_is_load(ex_is_load), .ex_rt(ex_rt), .ex_wr(ex_wr), .ex_dst(ex_dst),
    .mem_wr(mem_wr), .mem_dst(mem_dst), .id_rs(id_rs), .id_rt(id_rt),
    .id_branch(id_branch), .id_jump(id_jump), .cmp_eq(cmp_eq),
    .pc_we(pc_we), .ifid_we(ifid_we), .ctl_zero(ctl_zero), .if_flush(if_flush),
    .fwd_cmp_a(fwd_cmp_a), .fwd_cmp_b(fwd_cmp_b)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input int v);
    ex_is_load = v[0];
    ex_rt      = v[2:1];
    ex_wr      = v[3];
    ex_dst     = v[5:4];
    mem_wr     = v[6];
    mem_dst    = v[8:7];
    id_rs      = v[10:9];
    id_rt      = v[12:11];
    id_branch  = v[13];
    id_jump    = v[14];
    cmp_eq     = v[15];
  endtask

  task automatic check_all(input string ctx);
    logic lu, bd, st, fl, fa, fb;
    lu = ex_is_load && ((ex_rt == id_rs) || (ex_rt == id_rt));
    bd = id_branch && ex_wr && (ex_dst != 0) && ((ex_dst == id_rs) || (ex_dst == id_rt));
    st = lu || bd;
    fl = !st && (id_jump || (id_branch && cmp_eq));
    fa = id_branch && mem_wr && (mem_dst != 0) && (mem_dst == id_rs);
    fb = id_branch && mem_wr && (mem_dst != 0) && (mem_dst == id_rt);
    chk({ctx, " R2 pc_we"}, pc_we, !st);
    chk({ctx, " R2 ifid_we"}, ifid_we, !st);
    chk({ctx, lu ? " R1 ctl_zero" : (bd ? " R5 ctl_zero" : " R3 ctl_zero")}, ctl_zero, st);
    chk({ctx, (st && (id_jump || cmp_eq)) ? " R9 if_flush" : " R8 if_flush"}, if_flush, fl);
    chk({ctx, (mem_dst == 0) ? " R7 fwd_cmp_a" : " R6 fwd_cmp_a"}, fwd_cmp_a, fa);
    chk({ctx, (mem_dst == 0) ? " R7 fwd_cmp_b" : " R6 fwd_cmp_b"}, fwd_cmp_b, fb);
  endtask

  initial begin
    drive(0);
    repeat (3) @(posedge clk);
    #2;
    check_all("reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R4: a load in execute followed by the bubble it creates
    @(negedge clk);
    drive(0);
    ex_is_load = 1'b1; ex_rt = 2'd3; id_rs = 2'd3; id_rt = 2'd1;
    #1;
    chk("R1 load-use stall", ctl_zero, 1'b1);
    @(negedge clk);
    ex_is_load = 1'b0; ex_rt = 2'd0;
    #1;
    chk("R4 one bubble only pc_we", pc_we, 1'b1);
    chk("R4 one bubble only ctl_zero", ctl_zero, 1'b0);

    // R7: a zero destination in execute does not stall a branch
    @(negedge clk);
    drive(0);
    id_branch = 1'b1; ex_wr = 1'b1; ex_dst = 2'd0; id_rs = 2'd0; id_rt = 2'd0;
    #1;
    chk("R7 zero dst no branch stall", ctl_zero, 1'b0);

    // R9: a taken branch that depends on execute holds and does not flush
    @(negedge clk);
    ex_dst = 2'd2; id_rs = 2'd2; cmp_eq = 1'b1;
    #1;
    chk("R9 taken dependent branch no flush", if_flush, 1'b0);
    chk("R5 taken dependent branch holds", pc_we, 1'b0);

    // exhaustive sweep over all input combinations
    for (int v = 0; v < 65536; v++) begin
      @(negedge clk);
      drive(v);
      #1;
      check_all("sweep");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule